// File: doc/BRIEF.md
# Differential and Gray Sample Stream Decoder

This block sits on the receiving side of a link that carries 10-bit converter samples in a compressed form. Each incoming word may have been Gray coded, and may carry either an absolute sample or a difference against the sample sent two words earlier. The decoder undoes both steps. When Gray mode is on, it first turns the word back into plain binary. When differential mode is on and the word is not flagged as a reference, it then adds the result to the sample it rebuilt two accepted words earlier. The sum wraps modulo 1024.

A reference-flagged word, or any word while differential mode is off, is taken as the absolute sample. The two mode bits are independent of each other. The rebuilt sample comes out of a register, together with its own valid strobe, one clock after the input. In differential mode the valid strobe is held low until two reference words have arrived since reset, because before that the two-deep history holds nothing meaningful.

Top module: `diffgray_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `out_valid` is 0 and `out_sample` is 0 until a word is accepted.
- R2: `out_valid` is high in the cycle after a clock edge only if `in_valid` was high at that edge, so the latency is one clock. With `diff_en` low, every accepted word yields `out_valid` high one clock later.
- R3: With `gray_en` high, the received word g is decoded to binary b, where bit i of b is the XOR of bits 9 down to i of g. With `gray_en` low, the word is used unchanged.
- R4: With `diff_en` high and `in_ref` low, `out_sample` is (decoded word + rebuilt sample of the word accepted two words earlier) mod 1024. Any carry out of bit 9 is discarded.
- R5: With `in_ref` high or `diff_en` low, `out_sample` equals the decoded word. When `gray_en` is also low, that is the raw received word.
- R6: The two-deep history holds rebuilt samples, not received words. It advances on every accepted word, whatever the mode and whether or not `out_valid` is asserted. Before any word is accepted, the history holds 0.
- R7: With `diff_en` high, `out_valid` stays low for every accepted word until the second reference word since reset has been accepted. The word that carries that second reference, and every later one, gives `out_valid` high.
- R8: A clock edge with `in_valid` low leaves `out_sample` and the history unchanged, and gives `out_valid` low.
- R9: Encoding a sample stream as difference-against-two-back (mod 1024), optionally followed by binary-to-Gray, and then decoding it, reproduces every original sample. This holds in all four mode combinations and across wrap-around at 0 and 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is present on `in_word` this cycle |
| in_word | input | 10 | Encoded received word |
| in_ref | input | 1 | The word is an absolute reference sample |
| gray_en | input | 1 | Decode Gray to binary first |
| diff_en | input | 1 | Rebuild differential words against the history |
| out_valid | output | 1 | `out_sample` carries a valid rebuilt sample |
| out_sample | output | 10 | Registered rebuilt absolute sample |

## Verification
The assertions assume that the mode bits and the reference flag are read only in cycles when `in_valid` is high. They also assume that the sender's encoder and the decoder agree on the history, which holds only if every word the sender emits is delivered. The stimulus respects both conditions. It changes the mode bits only between words. Each word it sends comes from an encoder model that tracks the same last two samples the decoder rebuilds. Idle cycles are inserted without dropping any word. Mode switches in the middle of the stream stay meaningful because the encoder history advances on every sent word.

// File: rtl/dg_pkg.sv
package dg_pkg;

    localparam int DG_W          = 10;
    localparam int DG_LAG        = 2;
    localparam int DG_PRIME_REFS = 2;

    typedef logic [DG_W-1:0] dg_sample_t;

    typedef struct packed {
        logic       valid;
        dg_sample_t sample;
    } dg_out_t;

    typedef enum logic [1:0] {
        DG_PLAIN = 2'b00,
        DG_GRAY  = 2'b01,
        DG_DIFF  = 2'b10,
        DG_BOTH  = 2'b11
    } dg_mode_e;

    function automatic dg_sample_t dg_add_wrap(dg_sample_t a, dg_sample_t b);
        return a + b;
    endfunction

endpackage

// File: rtl/dg_gray_unit.sv
module dg_gray_unit #(
    parameter int W = 10
) (
    input  logic         gray_en,
    input  logic [W-1:0] word,
    output logic [W-1:0] bin
);
    logic [W-1:0] conv;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign conv[i] = ^word[W-1:i];
        end
    endgenerate

    assign bin = gray_en ? conv : word;
endmodule

// File: rtl/dg_history.sv
module dg_history #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] tap
);
    logic [DEPTH-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (push) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign tap = stage[DEPTH-1];
endmodule

// File: rtl/dg_prime_cnt.sv
module dg_prime_cnt #(
    parameter int TARGET = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_seen,
    output logic primed
);
    localparam int CW = $clog2(TARGET + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (ref_seen && cnt != CW'(TARGET)) begin
            cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    assign primed = (cnt_nxt == CW'(TARGET));
endmodule

// File: rtl/diffgray_decoder.sv
module diffgray_decoder
    import dg_pkg::*;
#(
    parameter int LAG        = DG_LAG,
    parameter int PRIME_REFS = DG_PRIME_REFS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [DG_W-1:0] in_word,
    input  logic            in_ref,
    input  logic            gray_en,
    input  logic            diff_en,
    output logic            out_valid,
    output logic [DG_W-1:0] out_sample
);
    dg_sample_t decoded;
    dg_sample_t lag_tap;
    dg_sample_t rebuilt;
    logic       primed;
    dg_mode_e   mode;
    dg_out_t    out_q;

    assign mode = dg_mode_e'({diff_en, gray_en});

    dg_gray_unit #(.W(DG_W)) u_gray (
        .gray_en (mode == DG_GRAY || mode == DG_BOTH),
        .word    (in_word),
        .bin     (decoded)
    );

    dg_history #(.W(DG_W), .DEPTH(LAG)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .push (in_valid),
        .din  (rebuilt),
        .tap  (lag_tap)
    );

    dg_prime_cnt #(.TARGET(PRIME_REFS)) u_prime (
        .clk      (clk),
        .rst      (rst),
        .ref_seen (in_valid & in_ref),
        .primed   (primed)
    );

    always_comb begin
        rebuilt = decoded;
        if ((mode == DG_DIFF || mode == DG_BOTH) && !in_ref) begin
            rebuilt = dg_add_wrap(decoded, lag_tap);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid & (~diff_en | primed);
            if (in_valid) begin
                out_q.sample <= rebuilt;
            end
        end
    end

    assign out_valid  = out_q.valid;
    assign out_sample = out_q.sample;
endmodule

// File: rtl/dg_decoder_checker.sv
module dg_decoder_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [9:0] in_word,
    input logic       in_ref,
    input logic       gray_en,
    input logic       diff_en,
    input logic       out_valid,
    input logic [9:0] out_sample
);
    logic [1:0] refs;

    always_ff @(posedge clk) begin
        if (rst) refs <= '0;
        else if (in_valid && in_ref && refs != 2'd2) refs <= refs + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    a_r2_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_plain_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !diff_en) |=> out_valid);

    a_r5_ref_passthrough: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !gray_en && (in_ref || !diff_en)) |=> out_sample == $past(in_word));

    a_r7_priming: assert property (@(posedge clk) disable iff (rst)
        (in_valid && diff_en && (32'(refs) + 32'(in_ref)) < 2) |=> !out_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));
endmodule

bind diffgray_decoder dg_decoder_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .in_ref     (in_ref),
    .gray_en    (gray_en),
    .diff_en    (diff_en),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/diffgray_decoder_tb.sv
module diffgray_decoder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [9:0] in_word;
    logic       in_ref;
    logic       gray_en;
    logic       diff_en;
    logic       out_valid;
    logic [9:0] out_sample;

    int checks = 0;
    int fails  = 0;

    int model_hist[$];
    int model_refs;
    int exp_sample;
    int exp_valid;
    int enc_hist[$];

    always #5 clk = ~clk;

    diffgray_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ref(in_ref), .gray_en(gray_en), .diff_en(diff_en),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int to_gray(int v);
        return (v ^ (v >> 1)) & 1023;
    endfunction

    function automatic int from_gray(int g);
        int b = 0;
        for (int i = 9; i >= 0; i--) begin
            int hi = (i == 9) ? 0 : ((b >> (i + 1)) & 1);
            b = b | (((hi ^ ((g >> i) & 1)) & 1) << i);
        end
        return b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_word(int w, bit r, bit g, bit d);
        int dec = g ? from_gray(w) : w;
        int rec = (d && !r) ? ((dec + model_hist[0]) % 1024) : dec;
        void'(model_hist.pop_front());
        model_hist.push_back(rec);
        if (r && model_refs < 2) model_refs++;
        exp_sample = rec;
        exp_valid  = (!d || model_refs >= 2) ? 1 : 0;
    endtask

    task automatic send_raw(int w, bit r, bit g, bit d, string req);
        @(negedge clk);
        in_valid = 1'b1; in_word = w[9:0]; in_ref = r; gray_en = g; diff_en = d;
        model_word(w, r, g, d);
        void'(enc_hist.pop_front());
        enc_hist.push_back(exp_sample);
        @(posedge clk); #1;
        in_valid = 1'b0;
        check({req, " valid"}, int'(out_valid), exp_valid);
        check({req, " sample"}, int'(out_sample), exp_sample);
    endtask

    // R9: encode an original sample, decode, compare with original
    task automatic send_orig(int orig, bit r, bit g, bit d);
        int v = (d && !r) ? ((orig - enc_hist[0] + 1024) % 1024) : orig;
        int w = g ? to_gray(v) : v;
        send_raw(w, r, g, d, "R9/R4 roundtrip");
        check("R9 original", int'(out_sample), orig);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_word = 10'h2AA; in_ref = 1'b1;
            @(posedge clk); #1;
            check("R8 idle valid", int'(out_valid), 0);
            check("R8 idle hold", int'(out_sample), exp_sample);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_hist = '{0, 0};
        enc_hist   = '{0, 0};
        model_refs = 0;
        exp_sample = 0;
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_ref = 1'b0;
        gray_en = 1'b0; diff_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset sample", int'(out_sample), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", int'(out_sample), 0);

        // R5/R2: plain mode, no references
        send_raw(1023, 0, 0, 0, "R5 plain");
        send_raw(0,    0, 0, 0, "R5 plain");
        idle(2);
        send_raw(517,  0, 0, 0, "R2 plain latency");

        // R3: Gray decode only
        send_raw(10'b1000000000, 0, 1, 0, "R3 gray 1023");
        send_raw(10'b1100000000, 0, 1, 0, "R3 gray 512");
        send_raw(10'b0000000001, 0, 1, 0, "R3 gray 1");
        send_raw(10'b1010101010, 0, 1, 0, "R3 gray mix");

        // R7: differential before priming, history uses rebuilt samples (R6)
        send_raw(3, 0, 0, 1, "R7 unprimed");
        send_raw(900, 1, 0, 1, "R7 first ref");
        send_raw(1000, 1, 0, 1, "R7 second ref");
        send_raw(200, 0, 0, 1, "R4 diff wrap");
        send_raw(24, 0, 0, 1, "R4 diff wrap");
        send_raw(1023, 0, 0, 1, "R6 history");

        // R9: round trips in all modes with wrap at 0 and 1023
        for (int m = 0; m < 4; m++) begin
            bit g = m[0];
            bit d = m[1];
            send_orig(1023, 1, g, d);
            send_orig(0,    1, g, d);
            send_orig(1,    0, g, d);
            send_orig(1022, 0, g, d);
            idle(1);
            send_orig(1023, 0, g, d);
            send_orig(0,    0, g, d);
            send_orig(512,  0, g, d);
            send_orig(511,  0, g, d);
            for (int k = 0; k < 20; k++) begin
                send_orig((k * 397 + m * 71) % 1024, (k % 9) == 0, g, d);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule